// File: doc/BRIEF.md
# Configuration-Space Target for a Multiplexed 32-bit Bus

This block is the configuration responder of a target on a 32-bit parallel bus where address and data share one set of wires. An initiator opens a transaction by pulling the start strobe low for one clock while it places the address on the shared lines and a command on the command/byte-enable lines. If the command is a configuration read or a configuration write, the block claims the transaction. It then runs a single data phase with a ready handshake, and returns a parity bit for every clock in which it drives read data. Every other command is left alone.

The configuration space is 64 dwords. The lower 16 dwords form a header with a fixed layout. It holds read-only identity values, a writable command word, base-address registers whose low bits report the decoded size, and an interrupt-line byte. The upper 48 dwords are plain byte-writable storage. All writes honour the active-low byte enables that the initiator presents during the data phase.

Top module: `cfg_space_target`

## Requirements
- R1: While reset is held, and until the first transaction, claim_n and ready_n are high and ad_oe and par_oe are low.
- R2: When the clock on which start_n falls carries command 4'b1010 (read) or 4'b1011 (write) on cbe_n, claim_n and ready_n go low on the next clock and stay low until the data phase completes. Both return high on the clock after completion.
- R3: An address phase with any other command is not claimed (claim_n stays high, ad_oe stays low) and changes no stored value.
- R4: The dword at byte offset 00h reads {DEVICE_ID, VENDOR_ID}, and writes to it have no effect.
- R5: At offset 04h, bits [15:0] are writable, and each byte is written only when its cbe_n bit is 0 in the data phase. Bits [31:16] read zero.
- R6: The dword at offset 08h reads CLASS_REV (class code in [31:8], revision in [7:0]) and cannot be written.
- R7: The memory base at 10h has bits [31:MEM_BAR_LOG2] writable and reads zero below them. The I/O base at 14h has bits [31:IO_BAR_LOG2] writable and reads 1 in bit 0. The expansion-ROM base at 30h has bits [31:ROM_LOG2] and bit 0 writable.
- R8: At 0Ch, bits [15:0] are writable. At 3Ch, bits [7:0] are writable and bits [15:8] read INT_PIN. All other bits of both dwords read zero.
- R9: Header dwords 18h to 2Ch, 34h and 38h read zero and ignore writes.
- R10: Dwords 40h to FCh store all 32 bits, with byte-enable masking on writes.
- R11: A data phase completes only on a clock where init_rdy_n is low. While init_rdy_n is high, the read data on ad_out holds steady and no write takes place.
- R12: On the clock after each clock in which ad_oe is high, par_oe is high and par_out equals the XOR of the previous clock's ad_out[31:0] and cbe_n[3:0] (even parity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low transaction strobe; its falling clock is the address phase |
| init_rdy_n | input | 1 | Active-low initiator ready |
| ad_in | input | 32 | Shared address/data lines as received |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| claim_n | output | 1 | Active-low target claim |
| ready_n | output | 1 | Active-low target ready |
| ad_out | output | 32 | Read data driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| par_out | output | 1 | Even parity over the previous driven cycle |
| par_oe | output | 1 | Drive enable for par_out |

## Verification
The parity bit for the last read data phase is driven on the clock that follows completion. That clock can also be the address phase of the next transaction, so parity output and command decode can fall in the same cycle. The bench issues transactions back to back with no idle clock between them. It checks that the late parity bit matches the finished read while the new command is claimed correctly on the following clock. A write followed at once by a read of the same dword also lands the storage update and the next address decode in adjacent cycles, and the read must return the new value.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } bus_state_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  localparam int HDR_WORDS   = 16;
  localparam int SPACE_WORDS = 64;

  // header dword indices (byte offset / 4)
  localparam int W_IDENT   = 0;
  localparam int W_CMD     = 1;
  localparam int W_CLASS   = 2;
  localparam int W_LINE    = 3;
  localparam int W_MEMBASE = 4;
  localparam int W_IOBASE  = 5;
  localparam int W_ROMBASE = 12;
  localparam int W_IRQ     = 15;

endpackage

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
  import cfg_space_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             init_rdy_n,
  input  logic [IDX_W-1:0] addr_word,
  input  logic [3:0]       cbe_n,
  output logic             claim_n,
  output logic             ready_n,
  output logic [IDX_W-1:0] idx,
  output logic             wr_stb,
  output logic             rd_drive
);

  bus_state_e       state_q, state_d;
  logic             start_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             is_wr_q, is_wr_d;
  logic             addr_fall, cmd_ok, phase_done;

  always_comb begin
    addr_fall  = start_q && !start_n && (state_q == ST_IDLE);
    cmd_ok     = (cbe_n == CMD_CFG_RD) || (cbe_n == CMD_CFG_WR);
    phase_done = (state_q == ST_DATA) && !init_rdy_n;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    is_wr_d = is_wr_q;
    case (state_q)
      ST_IDLE: begin
        if (addr_fall && cmd_ok) begin
          state_d = ST_DATA;
          idx_d   = addr_word;
          is_wr_d = (cbe_n == CMD_CFG_WR);
        end
      end
      ST_DATA: begin
        if (phase_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b1;
      idx_q   <= '0;
      is_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_n;
      idx_q   <= idx_d;
      is_wr_q <= is_wr_d;
    end
  end

  always_comb begin
    claim_n  = (state_q != ST_DATA);
    ready_n  = (state_q != ST_DATA);
    idx      = idx_q;
    wr_stb   = phase_done && is_wr_q;
    rd_drive = (state_q == ST_DATA) && !is_wr_q;
  end

  // R2: a configuration command is claimed on the next clock
  p_claim_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_fall && cmd_ok) |=> (!claim_n && !ready_n));

  // R2: claim released on the clock after completion
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_n && !init_rdy_n) |=> claim_n);

  // R3: other commands are not claimed
  p_ignore_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_fall && !cmd_ok) |=> claim_n);

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID    = 16'h0A57,
  parameter logic [31:0] CLASS_REV    = 32'h0B400003,
  parameter logic [7:0]  INT_PIN      = 8'h01,
  parameter int          MEM_BAR_LOG2 = 12,
  parameter int          IO_BAR_LOG2  = 5,
  parameter int          ROM_LOG2     = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  idx,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_be,
  output logic [31:0] rd_data
);

  function automatic logic [31:0] wmask(int w);
    case (w)
      W_CMD:     return 32'h0000FFFF;
      W_LINE:    return 32'h0000FFFF;
      W_MEMBASE: return 32'hFFFFFFFF << MEM_BAR_LOG2;
      W_IOBASE:  return 32'hFFFFFFFF << IO_BAR_LOG2;
      W_ROMBASE: return (32'hFFFFFFFF << ROM_LOG2) | 32'h1;
      W_IRQ:     return 32'h000000FF;
      default:   return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fixed_val(int w);
    case (w)
      W_IDENT:  return {DEVICE_ID, VENDOR_ID};
      W_CLASS:  return CLASS_REV;
      W_IOBASE: return 32'h1;
      W_IRQ:    return {16'h0, INT_PIN, 8'h0};
      default:  return 32'h0;
    endcase
  endfunction

  logic [31:0] byte_mask;
  logic [31:0] word [HDR_WORDS];

  always_comb begin
    byte_mask = {{8{wr_be[3]}}, {8{wr_be[2]}}, {8{wr_be[1]}}, {8{wr_be[0]}}};
  end

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
    localparam logic [31:0] M = wmask(g);
    localparam logic [31:0] F = fixed_val(g);
    if (M != 32'h0) begin : g_rw
      logic        hit;
      logic [31:0] q_r, q_d;
      always_comb begin
        hit = wr_en && (idx == 4'(g));
        q_d = (q_r & ~(M & byte_mask)) | (wr_data & M & byte_mask);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q_r <= '0;
        else if (hit) q_r <= q_d;
      end
      assign word[g] = (q_r & M) | F;
    end else begin : g_ro
      assign word[g] = F;
    end
  end

  always_comb rd_data = word[idx];

endmodule

// File: rtl/cfg_user_ram.sv
module cfg_user_ram #(
  parameter int DEPTH_W = 48,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  output logic [DATA_W-1:0] rd_data
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH_W];
  logic              in_range;

  always_comb begin
    in_range = int'(idx) < DEPTH_W;
    rd_data  = in_range ? mem[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH_W; i++) mem[i] <= '0;
    end else if (wr_en && in_range) begin
      for (int b = 0; b < LANES; b++) begin
        if (wr_be[b]) mem[idx][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  // R10: contents only move on a write
  p_ram_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!$stable(idx) || $stable(rd_data)));

endmodule

// File: rtl/cfg_parity_gen.sv
module cfg_parity_gen #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                drv_en,
  input  logic [DATA_W-1:0]   ad,
  input  logic [DATA_W/8-1:0] cbe_n,
  output logic                par,
  output logic                par_oe
);

  logic par_d, par_q, oe_q;

  always_comb par_d = ^{ad, cbe_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= drv_en;
      if (drv_en) par_q <= par_d;
    end
  end

  always_comb begin
    par    = par_q;
    par_oe = oe_q;
  end

endmodule

// File: rtl/cfg_space_target.sv
module cfg_space_target
  import cfg_space_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID    = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID    = 16'h0A57,
  parameter logic [31:0] CLASS_REV    = 32'h0B400003,
  parameter logic [7:0]  INT_PIN      = 8'h01,
  parameter int          MEM_BAR_LOG2 = 12,
  parameter int          IO_BAR_LOG2  = 5,
  parameter int          ROM_LOG2     = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_n,
  input  logic        init_rdy_n,
  input  logic [31:0] ad_in,
  input  logic [3:0]  cbe_n,
  output logic        claim_n,
  output logic        ready_n,
  output logic [31:0] ad_out,
  output logic        ad_oe,
  output logic        par_out,
  output logic        par_oe
);

  localparam int IDX_W     = $clog2(SPACE_WORDS);
  localparam int RAM_WORDS = SPACE_WORDS - HDR_WORDS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0] idx, ram_idx;
  logic             wr_stb, rd_drive, hdr_sel;
  logic [31:0]      hdr_rdata, ram_rdata;

  cfg_bus_fsm #(.IDX_W(IDX_W)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_n    (start_n),
    .init_rdy_n (init_rdy_n),
    .addr_word  (ad_in[IDX_W+1:2]),
    .cbe_n      (cbe_n),
    .claim_n    (claim_n),
    .ready_n    (ready_n),
    .idx        (idx),
    .wr_stb     (wr_stb),
    .rd_drive   (rd_drive)
  );

  always_comb begin
    hdr_sel = idx < IDX_W'(HDR_WORDS);
    ram_idx = idx - IDX_W'(HDR_WORDS);
  end

  cfg_header_regs #(
    .VENDOR_ID    (VENDOR_ID),
    .DEVICE_ID    (DEVICE_ID),
    .CLASS_REV    (CLASS_REV),
    .INT_PIN      (INT_PIN),
    .MEM_BAR_LOG2 (MEM_BAR_LOG2),
    .IO_BAR_LOG2  (IO_BAR_LOG2),
    .ROM_LOG2     (ROM_LOG2)
  ) hdr_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_stb && hdr_sel),
    .idx     (idx[3:0]),
    .wr_data (ad_in),
    .wr_be   (~cbe_n),
    .rd_data (hdr_rdata)
  );

  cfg_user_ram #(
    .DEPTH_W (RAM_WORDS),
    .DATA_W  (32),
    .IDX_W   (IDX_W)
  ) ram_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_stb && !hdr_sel),
    .idx     (ram_idx),
    .wr_data (ad_in),
    .wr_be   (~cbe_n),
    .rd_data (ram_rdata)
  );

  always_comb begin
    ad_oe  = rd_drive;
    ad_out = rd_drive ? (hdr_sel ? hdr_rdata : ram_rdata) : 32'h0;
  end

  cfg_parity_gen #(.DATA_W(32)) par_i (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .drv_en (ad_oe),
    .ad     (ad_out),
    .cbe_n  (cbe_n),
    .par    (par_out),
    .par_oe (par_oe)
  );

  // R12: every driven data clock is followed by a driven parity clock
  p_par_follows_r12: assert property (@(posedge clk) disable iff (!rst_int_n)
    ad_oe |=> par_oe);

  // R11: read data holds through initiator wait states
  p_hold_wait_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ad_oe && init_rdy_n) |=> (ad_oe && $stable(ad_out)));

  // R1: nothing driven while reset is active
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_int_n |-> (claim_n && !ad_oe));

endmodule

// File: tb/cfg_space_target_tb_top.sv
module cfg_space_target_tb_top;

  localparam logic [15:0] VEN  = 16'h1B2C;
  localparam logic [15:0] DEV  = 16'h0A57;
  localparam logic [31:0] CREV = 32'h0B400003;
  localparam logic [7:0]  IPIN = 8'h01;
  localparam int MEM_L = 12;
  localparam int IO_L  = 5;
  localparam int ROM_L = 14;

  logic        clk, rst_n, start_n, init_rdy_n;
  logic [31:0] ad_in;
  logic [3:0]  cbe_n;
  logic        claim_n, ready_n, ad_oe, par_out, par_oe;
  logic [31:0] ad_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [64];

  cfg_space_target #(
    .VENDOR_ID(VEN), .DEVICE_ID(DEV), .CLASS_REV(CREV), .INT_PIN(IPIN),
    .MEM_BAR_LOG2(MEM_L), .IO_BAR_LOG2(IO_L), .ROM_LOG2(ROM_L)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .init_rdy_n(init_rdy_n),
    .ad_in(ad_in), .cbe_n(cbe_n), .claim_n(claim_n), .ready_n(ready_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(int w);
    if (w >= 16) return 32'hFFFFFFFF;
    case (w)
      1, 3:    return 32'h0000FFFF;
      4:       return 32'hFFFFFFFF << MEM_L;
      5:       return 32'hFFFFFFFF << IO_L;
      12:      return (32'hFFFFFFFF << ROM_L) | 32'h1;
      15:      return 32'h000000FF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] fixedv(int w);
    case (w)
      0:       return {DEV, VEN};
      2:       return CREV;
      5:       return 32'h1;
      15:      return {16'h0, IPIN, 8'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int w);
    return (model[w] & wmask(w)) | fixedv(w);
  endfunction

  task automatic model_wr(int w, logic [31:0] d, logic [3:0] be_n);
    logic [31:0] bm;
    bm = {{8{~be_n[3]}}, {8{~be_n[2]}}, {8{~be_n[1]}}, {8{~be_n[0]}}} & wmask(w);
    model[w] = (model[w] & ~bm) | (d & bm);
  endtask

  task automatic cfg_write(int w, logic [31:0] d, logic [3:0] be_n, int waits, string req);
    @(negedge clk);
    start_n = 1'b0; ad_in = {24'h0, 6'(w), 2'b00}; cbe_n = 4'b1011;
    @(negedge clk);
    start_n = 1'b1; ad_in = d; cbe_n = be_n; init_rdy_n = (waits == 0) ? 1'b0 : 1'b1;
    #5 chk("R2 write claimed", {30'h0, claim_n, ready_n}, 32'h0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (i == waits - 1) init_rdy_n = 1'b0;
      #5 chk("R11 write held in wait", {30'h0, claim_n, ready_n}, 32'h0);
    end
    @(posedge clk);
    #5;
    init_rdy_n = 1'b1; ad_in = 32'h0; cbe_n = 4'hF;
    chk("R2 write released", {31'h0, claim_n}, 32'h1);
    model_wr(w, d, be_n);
  endtask

  task automatic cfg_read(int w, logic [3:0] be_n, int waits, string req);
    logic [31:0] e;
    e = exp_rd(w);
    @(negedge clk);
    start_n = 1'b0; ad_in = {24'h0, 6'(w), 2'b00}; cbe_n = 4'b1010;
    @(negedge clk);
    start_n = 1'b1; ad_in = 32'h0; cbe_n = be_n; init_rdy_n = (waits == 0) ? 1'b0 : 1'b1;
    #5;
    chk("R2 read claimed", {30'h0, claim_n, ready_n}, 32'h0);
    chk(req, ad_out, e);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (i == waits - 1) init_rdy_n = 1'b0;
      #5 chk("R11 read data held", ad_out, e);
    end
    @(posedge clk);
    #5;
    init_rdy_n = 1'b1; cbe_n = 4'hF;
    chk("R12 parity enable", {31'h0, par_oe}, 32'h1);
    chk("R12 parity value", {31'h0, par_out}, {31'h0, ^{e, be_n}});
    chk("R2 read released", {31'h0, claim_n}, 32'h1);
  endtask

  task automatic t_reset();
    chk("R1 claim idle", {30'h0, claim_n, ready_n}, 32'h3);
    chk("R1 drivers off", {30'h0, ad_oe, par_oe}, 32'h0);
  endtask

  task automatic t_ident();
    cfg_write(0, 32'hFFFFFFFF, 4'h0, 0, "R4");
    cfg_read(0, 4'h0, 0, "R4 identity read-only");
    cfg_write(2, 32'h12345678, 4'h0, 0, "R6");
    cfg_read(2, 4'h0, 0, "R6 class read-only");
  endtask

  task automatic t_command();
    cfg_write(1, 32'hDEADBEEF, 4'h0, 0, "R5");
    cfg_read(1, 4'h0, 0, "R5 command full write");
    cfg_write(1, 32'h12345678, 4'b1110, 0, "R5");
    cfg_read(1, 4'h0, 0, "R5 command byte enable");
  endtask

  task automatic t_bases();
    cfg_write(4, 32'hFFFFFFFF, 4'h0, 0, "R7");
    cfg_read(4, 4'h0, 0, "R7 memory base size");
    cfg_write(5, 32'hFFFFFFFF, 4'h0, 0, "R7");
    cfg_read(5, 4'h0, 0, "R7 io base size");
    cfg_write(12, 32'hFFFFFFFF, 4'h0, 0, "R7");
    cfg_read(12, 4'h0, 0, "R7 rom base size");
  endtask

  task automatic t_misc();
    cfg_write(3, 32'hA5A5A5A5, 4'h0, 0, "R8");
    cfg_read(3, 4'h0, 0, "R8 line/latency word");
    cfg_write(15, 32'hFFFFFF3C, 4'h0, 0, "R8");
    cfg_read(15, 4'h0, 0, "R8 interrupt word");
  endtask

  task automatic t_unimpl();
    cfg_write(6, 32'hFFFFFFFF, 4'h0, 0, "R9");
    cfg_read(6, 4'h0, 0, "R9 offset 18h zero");
    cfg_write(13, 32'hCAFEF00D, 4'h0, 0, "R9");
    cfg_read(13, 4'h0, 0, "R9 offset 34h zero");
  endtask

  task automatic t_storage();
    cfg_write(16, 32'h01234567, 4'h0, 0, "R10");
    cfg_write(16, 32'hFFFFFFFF, 4'b0101, 0, "R10");
    cfg_read(16, 4'h0, 0, "R10 storage byte enable");
    cfg_write(63, 32'h89ABCDEF, 4'h0, 0, "R10");
    cfg_read(63, 4'b0011, 0, "R10 storage top dword");
  endtask

  task automatic t_ignore();
    @(negedge clk);
    start_n = 1'b0; ad_in = 32'h00000040; cbe_n = 4'b0111;
    @(negedge clk);
    start_n = 1'b1; ad_in = 32'hBADBAD00; cbe_n = 4'h0; init_rdy_n = 1'b0;
    #5;
    chk("R3 other command not claimed", {31'h0, claim_n}, 32'h1);
    chk("R3 no drive", {31'h0, ad_oe}, 32'h0);
    @(posedge clk);
    #5 init_rdy_n = 1'b1; cbe_n = 4'hF; ad_in = 32'h0;
    cfg_read(16, 4'h0, 0, "R3 storage unchanged");
  endtask

  task automatic t_waits();
    cfg_write(20, 32'h5A5A0F0F, 4'h0, 3, "R11");
    cfg_read(20, 4'b1000, 4, "R11 read after waited write");
  endtask

  task automatic t_back_to_back();
    cfg_write(30, 32'h00FF00FF, 4'h0, 0, "R10");
    cfg_read(30, 4'h0, 0, "R12 back-to-back read 1");
    cfg_read(4, 4'b1111, 0, "R12 back-to-back read 2");
    cfg_read(0, 4'b0110, 0, "R12 back-to-back read 3");
  endtask

  logic done = 1'b0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 32'h0;
    rst_n = 1'b0; start_n = 1'b1; init_rdy_n = 1'b1; ad_in = 32'h0; cbe_n = 4'hF;
    repeat (2) @(negedge clk);
    #5 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5 t_reset();
    t_ident();
    t_command();
    t_bases();
    t_misc();
    t_unimpl();
    t_storage();
    t_ignore();
    t_waits();
    t_back_to_back();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule